// File: doc/BRIEF.md
# HDB3 Line Code Encoder

This block turns a serial NRZ bit stream into the three-level HDB3 line code. The code is carried on two unipolar rails, one for positive marks and one for negative marks. It runs on a single transmit clock at the line rate (2.048 or 8.448 Mbit/s) and takes one input bit per clock. Ones are sent as marks of alternating polarity. A run of zeros as long as the substitution length is replaced by a violation mark in its last position. When the line's DC balance needs it, a balancing mark is also placed in its first position.

The substitution is decided ahead of time. Incoming bits pass through a shift pipeline whose depth equals the substitution length. The last zero of a run is detected as it enters the pipeline, and both affected slots are tagged there. The polarity stage then resolves each tag when the slot leaves the pipeline. It does so from two pieces of state: the polarity of the last mark sent, and the parity of marks sent since the last violation. The rails are registered enable flags ANDed with the clock, so each mark is a return-to-zero pulse that lasts for the clock high phase.

Top module: `hdb3_line_encoder`

## Requirements
- R1: With the default substitution length of 4, the line never carries 4 consecutive zero slots that come from input data. Every run of 4 input zeros is substituted.
- R2: The last zero of a substituted run is sent as a mark whose polarity equals that of the mark sent just before it (a violation).
- R3: The first zero of a substituted run is sent as a mark of the polarity opposite to the previous mark if and only if an even number of marks were sent since the last violation. As a result, successive violations alternate in polarity.
- R4: Each input one that is not part of a substitution is sent as a mark whose polarity is opposite to the previous mark.
- R5: After reset, the first mark sent is positive and the last violation is taken to have been positive. The pipeline holds filler slots that are sent as zeros. Both rails are low while reset is held. A run of zeros with no earlier ones therefore gets no balancing mark and a negative violation.
- R6: line_pos (positive mark) and line_neg (negative mark) are never high in the same clock cycle.
- R7: The symbol for a bit sampled at clock edge k appears on the rails during the clock high phase after edge k+4.
- R8: Both rails are low while the clock is low (return-to-zero pulses).
- R9: Runs are grouped from their first zero. Eight zeros give two back-to-back substitutions, and a run shorter than 4 zeros passes through as plain zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit line-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nrz_in | input | 1 | Serial NRZ data, one bit per clock |
| line_pos | output | 1 | Positive-mark rail, pulses during clock high |
| line_neg | output | 1 | Negative-mark rail, pulses during clock high |

## Verification
The bench builds the block with its defaults: a substitution length of 4 and a two-stage reset synchronizer. This is the value the line standard uses. With it, the balancing and non-balancing branches, back-to-back substitutions and runs of one to three zeros are all reachable within streams of under twenty bits. A reference model in the bench walks each stream from its first zero to produce the expected ternary symbol for every slot. That model is then compared against rail samples taken in each clock high phase and each clock low phase.

// File: rtl/hdb3_enc_pkg.sv
package hdb3_enc_pkg;

  // Role of a slot travelling through the look-ahead pipeline
  typedef enum logic [1:0] {
    TAG_FILL = 2'd0,  // reset filler, always sent as a zero
    TAG_DATA = 2'd1,  // ordinary input bit
    TAG_LEAD = 2'd2,  // first zero of a substituted run
    TAG_VIOL = 2'd3   // last zero of a substituted run
  } slot_tag_t;

  typedef struct packed {
    logic      bit_v;
    slot_tag_t tag;
  } slot_t;

endpackage

// File: rtl/hdb3_zero_scan.sv
module hdb3_zero_scan
  import hdb3_enc_pkg::*;
#(
  parameter int ZRUN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nrz_in,
  output slot_t slot_out
);

  localparam int LAST = ZRUN - 1;

  slot_t stage_q [ZRUN];
  slot_t stage_d [ZRUN];
  logic  run_hit;

  // Next state: the newest bit completes a run when every younger stage
  // still holds an untouched data zero.
  always_comb begin
    run_hit = ~nrz_in;
    for (int i = 0; i < LAST; i++) begin
      if (stage_q[i].bit_v || (stage_q[i].tag != TAG_DATA)) begin
        run_hit = 1'b0;
      end
    end
    stage_d[0].bit_v = nrz_in;
    stage_d[0].tag   = run_hit ? TAG_VIOL : TAG_DATA;
    for (int i = 1; i < ZRUN; i++) begin
      stage_d[i] = stage_q[i-1];
    end
    if (run_hit) begin
      stage_d[LAST].tag = TAG_LEAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ZRUN; i++) begin
        stage_q[i] <= '{bit_v: 1'b0, tag: TAG_FILL};
      end
    end else begin
      for (int i = 0; i < ZRUN; i++) begin
        stage_q[i] <= stage_d[i];
      end
    end
  end

  assign slot_out = stage_q[LAST];

  // A substituted slot always carries a zero data bit
  assert_subst_is_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_out.tag == TAG_LEAD) || (slot_out.tag == TAG_VIOL)) |-> !slot_out.bit_v);

endmodule

// File: rtl/hdb3_mark_polarity.sv
module hdb3_mark_polarity
  import hdb3_enc_pkg::*;
#(
  parameter int ZRUN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t slot_in,
  output logic  pos_d,
  output logic  neg_d
);

  localparam int CW = $clog2(ZRUN + 1);

  logic last_pos_q, last_pos_d;   // polarity of last mark (1 = positive)
  logic par_odd_q,  par_odd_d;    // odd count of marks since last violation

  always_comb begin
    pos_d      = 1'b0;
    neg_d      = 1'b0;
    last_pos_d = last_pos_q;
    par_odd_d  = par_odd_q;
    unique case (slot_in.tag)
      TAG_DATA: begin
        if (slot_in.bit_v) begin
          pos_d      = ~last_pos_q;
          neg_d      = last_pos_q;
          last_pos_d = ~last_pos_q;
          par_odd_d  = ~par_odd_q;
        end
      end
      TAG_LEAD: begin
        if (!par_odd_q) begin
          pos_d      = ~last_pos_q;
          neg_d      = last_pos_q;
          last_pos_d = ~last_pos_q;
          par_odd_d  = 1'b1;
        end
      end
      TAG_VIOL: begin
        pos_d     = last_pos_q;
        neg_d     = ~last_pos_q;
        par_odd_d = 1'b0;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      par_odd_q  <= 1'b1;
    end else begin
      last_pos_q <= last_pos_d;
      par_odd_q  <= par_odd_d;
    end
  end

  // Checker state, built only from the emitted marks
  logic          chk_mark_pos;
  logic          chk_viol_pos;
  logic [CW-1:0] chk_zeros;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_mark_pos <= 1'b0;
      chk_viol_pos <= 1'b1;
      chk_zeros    <= '0;
    end else begin
      if (pos_d || neg_d) begin
        chk_mark_pos <= pos_d;
        chk_zeros    <= '0;
      end else if (slot_in.tag == TAG_FILL) begin
        chk_zeros    <= '0;
      end else if (chk_zeros != CW'(ZRUN)) begin
        chk_zeros    <= chk_zeros + 1'b1;
      end
      if (slot_in.tag == TAG_VIOL) begin
        chk_viol_pos <= pos_d;
      end
    end
  end

  assert_zero_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_zeros < CW'(ZRUN));

  assert_viol_same_pol_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_in.tag == TAG_VIOL) |-> (pos_d == chk_mark_pos) && (neg_d == !chk_mark_pos));

  assert_viol_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_in.tag == TAG_VIOL) |-> (pos_d != chk_viol_pos));

  assert_ami_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_in.tag == TAG_DATA) && slot_in.bit_v) |->
      (pos_d == !chk_mark_pos) && (neg_d == chk_mark_pos));

endmodule

// File: rtl/hdb3_rail_gate.sv
module hdb3_rail_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_d,
  input  logic neg_d,
  output logic line_pos,
  output logic line_neg
);

  logic pos_q, neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      neg_q <= neg_d;
    end
  end

  // Return-to-zero: each flag is visible only during the clock high phase
  assign line_pos = pos_q & clk;
  assign line_neg = neg_q & clk;

  assert_rails_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_q && neg_q));

endmodule

// File: rtl/hdb3_line_encoder.sv
module hdb3_line_encoder
  import hdb3_enc_pkg::*;
#(
  parameter int ZRUN     = 4,
  parameter int RST_SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_in,
  output logic line_pos,
  output logic line_neg
);

  logic [RST_SYNC-1:0] rst_sync_q;
  logic                rst_int_n;
  slot_t               slot_w;
  logic                pos_w, neg_w;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[RST_SYNC-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[RST_SYNC-1];

  hdb3_zero_scan #(.ZRUN(ZRUN)) u_scan (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .nrz_in   (nrz_in),
    .slot_out (slot_w)
  );

  hdb3_mark_polarity #(.ZRUN(ZRUN)) u_pol (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .slot_in (slot_w),
    .pos_d   (pos_w),
    .neg_d   (neg_w)
  );

  hdb3_rail_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pos_d    (pos_w),
    .neg_d    (neg_w),
    .line_pos (line_pos),
    .line_neg (line_neg)
  );

endmodule

// File: tb/hdb3_line_encoder_bench.sv
module hdb3_line_encoder_bench;

  localparam int N    = 4;
  localparam int MAXL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nrz = 1'b1;
  logic line_pos, line_neg;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int stim    [MAXL];
  int exp_sym [MAXL];
  int stim_len = 0;

  always #10 clk = ~clk;

  hdb3_line_encoder u_hdb3_line_encoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .nrz_in   (nrz),
    .line_pos (line_pos),
    .line_neg (line_neg)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic load(input string s);
    stim_len = s.len();
    for (int i = 0; i < s.len(); i++) stim[i] = (s[i] == 8'h31) ? 1 : 0;
  endtask

  // Reference model: +1 positive mark, -1 negative mark, 0 space
  task automatic build_model();
    int last_pos = 0;
    int par_odd  = 1;
    int i = 0;
    for (int k = 0; k < MAXL; k++) exp_sym[k] = 0;
    while (i < stim_len) begin
      bit run = (stim[i] == 0) && (i + N <= stim_len);
      if (run) for (int j = 0; j < N; j++) if (stim[i+j] != 0) run = 0;
      if (stim[i] == 1) begin
        last_pos = 1 - last_pos;
        exp_sym[i] = last_pos ? 1 : -1;
        par_odd = 1 - par_odd;
        i++;
      end else if (run) begin
        if (par_odd == 0) begin
          last_pos = 1 - last_pos;
          exp_sym[i] = last_pos ? 1 : -1;
        end
        exp_sym[i+N-1] = last_pos ? 1 : -1;
        par_odd = 0;
        i += N;
      end else begin
        i++;
      end
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    nrz = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    check(!line_pos && !line_neg, "R5", "rails during reset",
          int'(line_pos) + int'(line_neg), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  function automatic int rail_sym();
    if (line_pos && line_neg) return 2;
    if (line_pos) return 1;
    if (line_neg) return -1;
    return 0;
  endfunction

  task automatic run_stream(input string req);
    apply_reset();
    build_model();
    for (int c = 0; c < stim_len + N; c++) begin
      int expv;
      @(negedge clk);
      nrz = (c < stim_len) ? stim[c][0] : 1'b1;
      #5;
      check(!line_pos && !line_neg, "R8", "rails in clock low",
            int'(line_pos) + int'(line_neg), 0);
      @(posedge clk);
      #5;
      expv = (c < N) ? 0 : exp_sym[c-N];
      check(!(line_pos && line_neg), "R6", "both rails high", rail_sym(), expv);
      check(rail_sym() == expv, req, $sformatf("slot %0d", c), rail_sym(), expv);
    end
  endtask

  task automatic t_reset_state();  load("00001111");           run_stream("R5"); endtask
  task automatic t_ami();          load("11111111");           run_stream("R4"); endtask
  task automatic t_balance();      load("1000011");            run_stream("R3"); endtask
  task automatic t_violation();    load("110000100000000101"); run_stream("R2"); endtask
  task automatic t_long_zeros();   load("000000000000000011"); run_stream("R1"); endtask
  task automatic t_short_runs();   load("1001000100110");      run_stream("R9"); endtask
  task automatic t_latency();      load("0001");               run_stream("R7"); endtask

  initial begin
    t_reset_state();
    t_ami();
    t_balance();
    t_violation();
    t_long_zeros();
    t_short_runs();
    t_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule